// File: doc/BRIEF.md
# Misaligned Memory Access Sequencer

This block sits between a processor core and an external memory bus. The core hands it one transfer at a time: a byte address, a size (one byte or one 16-bit word), a direction and, for writes, the data. The sequencer turns that transfer into the bus cycles the attached memory can actually carry out. For a read it returns the assembled data, and for a write it reports completion.

The width of the memory bus is a parameter. It is either one byte or one 16-bit word. The word-wide bus has no byte enables. On that bus, a byte store is therefore done as a read-modify-write of the containing word. A word transfer that starts on an odd address is split into two byte transfers. Multi-byte values are little-endian, and the lower-addressed byte always moves first.

A bus cycle is presented with an address, a direction and write data. The cycle ends on the first rising clock edge at which the wait input is low. The core side uses a valid/ready handshake. The sequencer reports each finished transfer with a single-cycle done pulse.

Top module: `mem_seq`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and no bus cycle is active (bus_req = 0).
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1, and the first bus cycle starts in the next cycle. req_ready stays 0 until the transfer ends. done is high for exactly one cycle after the final bus cycle completes, and req_ready is 1 in that same cycle.
- R3: A bus cycle completes on the rising edge where bus_req = 1 and bus_wait = 0. While bus_wait holds a cycle, bus_addr, bus_we and bus_wdata stay constant. On the word-wide bus, bus_addr bit 0 is always 0.
- R4: A byte read (req_size = 0) is one bus read of the word that contains the address. The byte lane selected by address bit 0 on the word bus (the only lane on the byte bus) is returned in rd_data[7:0], and rd_data[15:8] is 0.
- R5: On the byte-wide bus, a byte write is exactly one bus write of req_wdata[7:0] to req_addr.
- R6: On the word-wide bus, a byte write is a read of the containing word followed by a write of that word. In the written word, lane address-bit-0 is replaced by req_wdata[7:0] and the other lane keeps the value just read.
- R7: On the byte-wide bus, a word transfer (req_size = 1) is two byte cycles: first at req_addr with data bits [7:0], then at req_addr+1 (modulo 2^ADDR_W) with bits [15:8]. A read returns the first byte in rd_data[7:0] and the second in rd_data[15:8].
- R8: On the word-wide bus, a word transfer at an even address is a single bus cycle that carries all 16 bits, with bits [7:0] belonging to the even address.
- R9: On the word-wide bus, a word transfer at an odd address is done as two byte transfers: the byte at req_addr first, then the byte at req_addr+1 (modulo 2^ADDR_W). Each follows R4 or R6, so a read takes two bus reads and a write takes read, write, read, write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents a transfer |
| req_ready | output | 1 | Sequencer can accept a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = 16-bit word |
| req_addr | input | ADDR_W | Byte address of the transfer |
| req_wdata | input | 16 | Write data, low byte for the lower address |
| done | output | 1 | One-cycle pulse when a transfer ends |
| rd_data | output | 16 | Assembled read data, valid with done |
| bus_req | output | 1 | A bus cycle is active |
| bus_we | output | 1 | Direction of the active bus cycle, 1 = write |
| bus_addr | output | ADDR_W | Byte address of the bus cycle |
| bus_wdata | output | 8*BUS_BYTES | Bus write data |
| bus_rdata | input | 8*BUS_BYTES | Bus read data |
| bus_wait | input | 1 | High extends the current bus cycle |

## Verification
The hardest situation to reach is an odd-address word store on the word bus whose second half wraps from the top of the address space to address zero, while wait states land between the read and the write of each half. It is only correct if the merged word carries the value just read for the untouched lane. The stimulus drives every size and direction at odd and even addresses, including the last two addresses before the wrap. It does this once with no wait states and again with pseudo-random wait states, against a byte-array memory that both bus widths share in form. Each bus cycle is compared with an expected cycle list that the bench builds from the requirements when it issues the request.

// File: rtl/msq_pkg.sv
package msq_pkg;
   localparam int BYTE_W     = 8;
   localparam int WORD_BYTES = 2;
   localparam int WORD_W     = BYTE_W * WORD_BYTES;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } msq_state_e;
endpackage

// File: rtl/msq_lane.sv
// Byte-lane picker and merger for a multi-lane bus word.
module msq_lane #(
   parameter  int BUS_BYTES = 2,
   localparam int SEL_W     = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1,
   localparam int BUS_W     = BUS_BYTES * msq_pkg::BYTE_W
) (
   input  logic [SEL_W-1:0]          lane_sel,
   input  logic [BUS_W-1:0]          bus_word,
   input  logic [msq_pkg::BYTE_W-1:0] new_byte,
   output logic [msq_pkg::BYTE_W-1:0] pick,
   output logic [BUS_W-1:0]          merged
);
   localparam int BW = msq_pkg::BYTE_W;

   assign pick = bus_word[lane_sel*BW +: BW];

   for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
      assign merged[g*BW +: BW] = (lane_sel == SEL_W'(g)) ? new_byte : bus_word[g*BW +: BW];
   end
endmodule

// File: rtl/msq_ctrl.sv
// Bus-cycle sequencing: which piece, which phase, when finished.
module msq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic in_wr,
   input  logic in_rmw,
   input  logic in_two,
   input  logic bus_wait,
   output logic busy,
   output logic bus_we,
   output logic piece,
   output logic ready,
   output logic done
);
   import msq_pkg::*;

   msq_state_e state;
   logic       op_wr, op_rmw, op_two;
   logic       ack, last;

   assign busy   = (state != ST_IDLE);
   assign bus_we = (state == ST_WR);
   assign ready  = (state == ST_IDLE);
   assign ack    = busy && !bus_wait;
   assign last   = !op_two || piece;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         piece  <= 1'b0;
         done   <= 1'b0;
         op_wr  <= 1'b0;
         op_rmw <= 1'b0;
         op_two <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               piece  <= 1'b0;
               op_wr  <= in_wr;
               op_rmw <= in_rmw;
               op_two <= in_two;
               state  <= (in_wr && !in_rmw) ? ST_WR : ST_RD;
            end
            ST_RD: if (ack) begin
               if (op_wr) begin
                  state <= ST_WR;
               end else if (last) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  piece <= 1'b1;
               end
            end
            ST_WR: if (ack) begin
               if (last) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  piece <= 1'b1;
                  state <= op_rmw ? ST_RD : ST_WR;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mem_seq.sv
// Splits core byte/word transfers into legal bus cycles.
module mem_seq #(
   parameter  int ADDR_W    = 16,
   parameter  int BUS_BYTES = 2,
   localparam int BUS_W     = BUS_BYTES * msq_pkg::BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [15:0]       req_wdata,
   output logic              done,
   output logic [15:0]       rd_data,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [BUS_W-1:0]  bus_wdata,
   input  logic [BUS_W-1:0]  bus_rdata,
   input  logic              bus_wait
);
   import msq_pkg::*;

   if (!(BUS_BYTES == 1 || BUS_BYTES == 2)) begin : g_bad_bus
      $error("mem_seq: BUS_BYTES must be 1 or 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("mem_seq: ADDR_W must be at least 2");
   end

   logic              start, in_rmw, in_two, piece, rd_ack;
   logic [ADDR_W-1:0] r_addr, p_addr;
   logic [WORD_W-1:0] r_wdata, rbuf;
   logic [BYTE_W-1:0] p_byte;

   assign start  = req_valid && req_ready;
   assign p_addr = r_addr + ADDR_W'(piece);
   assign p_byte = piece ? r_wdata[15:8] : r_wdata[7:0];
   assign rd_ack = bus_req && !bus_we && !bus_wait;
   assign rd_data = rbuf;

   msq_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .in_wr    (req_write),
      .in_rmw   (in_rmw),
      .in_two   (in_two),
      .bus_wait (bus_wait),
      .busy     (bus_req),
      .bus_we   (bus_we),
      .piece    (piece),
      .ready    (req_ready),
      .done     (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_addr  <= '0;
         r_wdata <= '0;
      end else if (start) begin
         r_addr  <= req_addr;
         r_wdata <= req_wdata;
      end
   end

   if (BUS_BYTES == 1) begin : g_narrow
      // every transfer is a string of single-byte cycles
      assign in_rmw    = 1'b0;
      assign in_two    = req_size;
      assign bus_addr  = p_addr;
      assign bus_wdata = p_byte;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rbuf <= '0;
         else if (start)  rbuf <= '0;
         else if (rd_ack) begin
            if (piece) rbuf[15:8] <= bus_rdata;
            else       rbuf[7:0]  <= bus_rdata;
         end
      end
   end else begin : g_wide
      logic              in_whole, r_whole;
      logic [BUS_W-1:0]  hold, merged;
      logic [BYTE_W-1:0] pick;

      assign in_whole  = req_size && !req_addr[0];
      assign in_rmw    = !in_whole;
      assign in_two    = req_size && !in_whole;
      assign bus_addr  = {p_addr[ADDR_W-1:1], 1'b0};
      assign bus_wdata = r_whole ? r_wdata : merged;

      msq_lane #(.BUS_BYTES(BUS_BYTES)) u_lane (
         .lane_sel (p_addr[0]),
         .bus_word (hold),
         .new_byte (p_byte),
         .pick     (pick),
         .merged   (merged)
      );

      logic [BYTE_W-1:0] pick_now;
      assign pick_now = p_addr[0] ? bus_rdata[15:8] : bus_rdata[7:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_whole <= 1'b0;
            hold    <= '0;
            rbuf    <= '0;
         end else if (start) begin
            r_whole <= in_whole;
            rbuf    <= '0;
         end else if (rd_ack) begin
            hold <= bus_rdata;
            if (r_whole)    rbuf       <= bus_rdata;
            else if (piece) rbuf[15:8] <= pick_now;
            else            rbuf[7:0]  <= pick_now;
         end
      end

      logic unused_pick;
      assign unused_pick = ^pick;
   end
endmodule

// File: rtl/msq_chk.sv
// Protocol checker attached to every mem_seq instance.
module msq_chk #(
   parameter  int ADDR_W    = 16,
   parameter  int BUS_BYTES = 2,
   localparam int BUS_W     = BUS_BYTES * 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              done,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic              bus_wait
);
   // R2
   ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> !req_ready);

   // R2
   accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> bus_req);

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   // R3
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wait) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

   if (BUS_BYTES > 1) begin : g_even
      // R3
      even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bus_req |-> !bus_addr[0]);
   end
endmodule

bind mem_seq msq_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wait  (bus_wait)
);

// File: tb/mem_seq_tb.sv
`timescale 1ns/1ps

module mem_seq_env #(
   parameter int BB = 2
) (
   input  logic clk,
   input  logic rst_n,
   output int   n_chk,
   output int   n_fail,
   output logic fin
);
   localparam int BW = BB * 8;

   logic          req_valid = 0, req_write = 0, req_size = 0;
   logic [7:0]    req_addr = 0;
   logic [15:0]   req_wdata = 0;
   logic          req_ready, done, bus_req, bus_we;
   logic [15:0]   rd_data;
   logic [7:0]    bus_addr;
   logic [BW-1:0] bus_wdata, bus_rdata;
   logic          bus_wait = 0;

   logic [7:0]    mem     [256];
   logic [7:0]    ref_mem [256];
   logic [24:0]   exp_q [$];
   string         cur_tag = "R1";
   bit            wait_mode = 0;
   logic [15:0]   lfsr = 16'hACE1;
   bit            hold_pend = 0;
   logic [7:0]    h_addr;
   logic          h_we;
   logic [15:0]   h_wd;

   mem_seq #(.ADDR_W(8), .BUS_BYTES(BB)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .bus_req(bus_req),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_wait(bus_wait)
   );

   if (BB == 1) begin : g_rd8
      assign bus_rdata = mem[bus_addr];
   end else begin : g_rd16
      assign bus_rdata = {mem[{bus_addr[7:1], 1'b1}], mem[{bus_addr[7:1], 1'b0}]};
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // bus model: choose wait, then judge the cycle that ends at the next edge
   always @(negedge clk) begin
      logic [15:0] wd16;
      logic [24:0] e;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_wait = rst_n && wait_mode && lfsr[0];
      wd16 = 16'(bus_wdata);
      if (hold_pend)
         chk(bus_req && bus_addr == h_addr && bus_we == h_we && wd16 == h_wd,
             "R3", "bus cycle changed under wait", int'(bus_addr), int'(h_addr));
      hold_pend = bus_req && bus_wait;
      h_addr = bus_addr; h_we = bus_we; h_wd = wd16;
      if (bus_req && !bus_wait) begin
         if (exp_q.size() == 0) begin
            chk(0, cur_tag, "unexpected bus cycle at", int'(bus_addr), 0);
         end else begin
            e = exp_q.pop_front();
            chk(bus_addr == e[24:17] && bus_we == e[16] && (!e[16] || wd16 == e[15:0]),
                cur_tag, "bus cycle {addr,we,data}",
                int'({bus_addr, bus_we, e[16] ? wd16 : 16'h0}), int'(e));
         end
         if (bus_we) begin
            if (BB == 1) mem[bus_addr] = wd16[7:0];
            else begin
               mem[{bus_addr[7:1], 1'b0}] = wd16[7:0];
               mem[{bus_addr[7:1], 1'b1}] = wd16[15:8];
            end
         end
      end
   end

   task automatic do_req(input bit wr, input bit sz, input logic [7:0] a, input logic [15:0] wd);
      string       tag;
      logic [15:0] exp_rd, cur;
      logic [7:0]  pa, wa, b;
      bit          busy_bad;
      if (!sz)        tag = !wr ? "R4" : (BB == 1 ? "R5" : "R6");
      else if (BB==1) tag = "R7";
      else            tag = a[0] ? "R9" : "R8";
      cur_tag = tag;
      exp_rd = sz ? {ref_mem[8'(a + 8'd1)], ref_mem[a]} : {8'h00, ref_mem[a]};
      if (BB == 2 && sz && !a[0]) begin
         exp_q.push_back({a, wr, wr ? wd : 16'h0});
         if (wr) begin ref_mem[a] = wd[7:0]; ref_mem[{a[7:1], 1'b1}] = wd[15:8]; end
      end else begin
         for (int k = 0; k < (sz ? 2 : 1); k++) begin
            pa = 8'(a + 8'(k));
            b  = (k == 1) ? wd[15:8] : wd[7:0];
            if (BB == 1) begin
               exp_q.push_back({pa, wr, wr ? {8'h00, b} : 16'h0});
               if (wr) ref_mem[pa] = b;
            end else begin
               wa = {pa[7:1], 1'b0};
               exp_q.push_back({wa, 1'b0, 16'h0});
               if (wr) begin
                  cur = {ref_mem[{pa[7:1], 1'b1}], ref_mem[wa]};
                  if (pa[0]) cur[15:8] = b; else cur[7:0] = b;
                  exp_q.push_back({wa, 1'b1, cur});
                  ref_mem[pa] = b;
               end
            end
         end
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 0;
      chk(!req_ready, "R2", "ready after accept", int'(req_ready), 0);
      busy_bad = 0;
      while (!done) begin
         if (req_ready) busy_bad = 1;
         @(negedge clk);
      end
      chk(!busy_bad, "R2", "ready high while busy", int'(busy_bad), 0);
      chk(exp_q.size() == 0, tag, "bus cycles still expected", exp_q.size(), 0);
      if (!wr) chk(rd_data == exp_rd, tag, "read data", int'(rd_data), int'(exp_rd));
      chk(req_ready, "R2", "ready with done", int'(req_ready), 1);
      exp_q.delete();
      @(negedge clk);
      chk(!done, "R2", "done longer than one cycle", int'(done), 0);
   endtask

   initial begin
      int bad;
      logic [7:0] alist [5];
      n_chk = 0; n_fail = 0; fin = 0;
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i * 37 + 5);
         ref_mem[i] = mem[i];
      end
      alist = '{8'h20, 8'h21, 8'hFE, 8'hFF, 8'h00};
      @(posedge rst_n);
      @(negedge clk);
      chk(req_ready && !done && !bus_req, "R1", "reset state {ready,done,bus_req}",
          int'({req_ready, done, bus_req}), 3'b100);
      for (int m = 0; m < 2; m++) begin
         wait_mode = (m == 1);
         for (int j = 0; j < 5; j++) begin
            for (int s = 0; s < 2; s++) begin
               do_req(0, s[0], alist[j], 16'h0);
               do_req(1, s[0], alist[j], 16'h5A00 + 16'(j * 16 + s + m * 4));
               do_req(0, s[0], alist[j], 16'h0);
            end
         end
      end
      wait_mode = 1;
      for (int i = 0; i < 150; i++) begin
         logic [31:0] r;
         r = $urandom;
         do_req(r[0], r[1], r[9:2], r[31:16]);
      end
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
      chk(bad == 0, (BB == 1) ? "R5" : "R6", "memory image mismatches", bad, 0);
      fin = 1;
   end
endmodule

module mem_seq_tb;
   logic clk = 0;
   logic rst_n = 0;
   int   cw, fw, cb, fb, cycles;
   logic fin_w, fin_b;

   always #2 clk = ~clk;

   mem_seq_env #(.BB(2)) u_env_w (.clk(clk), .rst_n(rst_n), .n_chk(cw), .n_fail(fw), .fin(fin_w));
   mem_seq_env #(.BB(1)) u_env_b (.clk(clk), .rst_n(rst_n), .n_chk(cb), .n_fail(fb), .fin(fin_b));

   initial begin
      int extra_c, extra_f;
      extra_c = 0; extra_f = 0; cycles = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      while (!(fin_w === 1'b1 && fin_b === 1'b1) && cycles < 100000) begin
         @(negedge clk);
         cycles++;
      end
      if (cycles >= 100000) begin
         extra_c = 1; extra_f = 1;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      end
      $display("TB_RESULT checks=%0d failures=%0d", cw + cb + extra_c, fw + fb + extra_f);
      $finish;
   end
endmodule